// File: doc/BRIEF.md
# Coherence-Point Atomic Bank with Broadcast Update

This block is one bank of a shared last-level cache that many processor clusters see as the single point of coherence. It holds a small internal word array, serves plain global loads and stores, and executes read-modify-write atomics (increment, decrement, add, exchange) inside the bank. Because every operation on a word happens in this one place, all cores observe one order of operations per word. There is no ownership handshake: the bank accepts one request per cycle and pipelines it.

Each request carries an opcode, a word address, a 32-bit operand and a requester tag. Two cycles after a request is accepted, the bank returns the word's value from before the operation, together with the tag. A forwarding path lets a request to the same word in the very next cycle see the result of the one before it, with no stall. A broadcast-update request writes the operand into the word and then raises a one-cycle notification on every cluster port carrying the address and the new value.

Top module: `atom_bank`

## Requirements
- R1: While reset is high and in the first cycle after it falls, rsp_valid is 0 and every bit of note_valid is 0.
- R2: A request driven with req_valid=1 in cycle N gives rsp_valid=1 in cycle N+2 with rsp_id equal to its req_id; a cycle with req_valid=0 gives rsp_valid=0 two cycles later. Every response returns the word's value from before that request.
- R3: Opcode 2 (increment) stores the prior value plus 1 modulo 2^32, so 0xFFFFFFFF becomes 0.
- R4: Opcode 3 (decrement) stores the prior value minus 1 modulo 2^32, so 0 becomes 0xFFFFFFFF.
- R5: Opcode 4 (add) stores the prior value plus the operand modulo 2^32; opcode 5 (exchange) stores the operand.
- R6: Opcode 0 (load) leaves the word unchanged; opcode 1 (store) writes the operand.
- R7: Requests to the same word issued in consecutive cycles, with no idle cycle between them, each see the result of the one before, in issue order.
- R8: Opcode 6 (broadcast update) stores the operand; a request driven in cycle N raises all bits of note_valid for exactly cycle N+3, and each port's address and data fields carry the address and the new value. note_valid is 0 in every cycle that has no such notification.
- R9: Opcode 7 is reserved and acts as a load: it returns the word and leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Opcode (0 load, 1 store, 2 inc, 3 dec, 4 add, 5 exchange, 6 broadcast, 7 reserved) |
| req_addr | input | ADDR_W (6) | Word address |
| req_operand | input | DATA_W (32) | Operand for store, add, exchange, broadcast |
| req_id | input | ID_W (4) | Requester tag |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | DATA_W (32) | Word value before the operation |
| rsp_id | output | ID_W (4) | Tag of the request being answered |
| note_valid | output | N_CLUST (4) | Notification pulse, one bit per cluster |
| note_addr | output | N_CLUST*ADDR_W (24) | Notified address, cluster c in bits [c*ADDR_W +: ADDR_W] |
| note_data | output | N_CLUST*DATA_W (128) | Notified value, cluster c in bits [c*DATA_W +: DATA_W] |

## Verification
A corrupted word or a lost update shows up at the next response that touches that word. That response comes two cycles after the request, and it does not wait for any later read. A wrong forwarding decision shows up only under back-to-back requests to one word, as a stale prior value in the second response. For that reason the stimulus keeps most addresses in a small set and issues requests on most cycles. A broadcast fault shows up three cycles after the request, as a missing pulse, a pulse on only some ports, a pulse that lasts too long, or a wrong address or value.

// File: rtl/atom_bank_pkg.sv
package atom_bank_pkg;
  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_INC   = 3'd2,
    OP_DEC   = 3'd3,
    OP_ADD   = 3'd4,
    OP_XCHG  = 3'd5,
    OP_BCAST = 3'd6,
    OP_RSVD  = 3'd7
  } op_e;
endpackage

// File: rtl/atom_bank_alu.sv
module atom_bank_alu
  import atom_bank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  op_e               op,
  input  logic [DATA_W-1:0] old_val,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] new_val,
  output logic              writes
);
  always_comb begin
    new_val = old_val;
    writes  = 1'b0;
    unique case (op)
      OP_STORE, OP_XCHG, OP_BCAST: begin
        new_val = operand;
        writes  = 1'b1;
      end
      OP_INC: begin
        new_val = old_val + DATA_W'(1);
        writes  = 1'b1;
      end
      OP_DEC: begin
        new_val = old_val - DATA_W'(1);
        writes  = 1'b1;
      end
      OP_ADD: begin
        new_val = old_val + operand;
        writes  = 1'b1;
      end
      default: begin
        new_val = old_val;
        writes  = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/atom_bank_mem.sv
module atom_bank_mem #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store_q [DEPTH];

  // read-first single-clock array, suitable for block RAM
  always_ff @(posedge clk) begin
    if (wr_en) store_q[wr_addr] <= wr_data;
    rd_data <= store_q[rd_addr];
  end
endmodule

// File: rtl/atom_bank_notify.sv
module atom_bank_notify #(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 32,
  parameter int N_CLUST = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        fire,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           data,
  output logic [N_CLUST-1:0]          note_valid,
  output logic [N_CLUST*ADDR_W-1:0]   note_addr,
  output logic [N_CLUST*DATA_W-1:0]   note_data
);
  for (genvar c = 0; c < N_CLUST; c++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst) begin
        note_valid[c]                  <= 1'b0;
        note_addr[c*ADDR_W +: ADDR_W]  <= '0;
        note_data[c*DATA_W +: DATA_W]  <= '0;
      end else begin
        note_valid[c] <= fire;
        if (fire) begin
          note_addr[c*ADDR_W +: ADDR_W] <= addr;
          note_data[c*DATA_W +: DATA_W] <= data;
        end
      end
    end
  end
endmodule

// File: rtl/atom_bank.sv
module atom_bank
  import atom_bank_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 32,
  parameter int ID_W    = 4,
  parameter int N_CLUST = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  input  logic [2:0]                req_op,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [DATA_W-1:0]         req_operand,
  input  logic [ID_W-1:0]           req_id,
  output logic                      rsp_valid,
  output logic [DATA_W-1:0]         rsp_data,
  output logic [ID_W-1:0]           rsp_id,
  output logic [N_CLUST-1:0]        note_valid,
  output logic [N_CLUST*ADDR_W-1:0] note_addr,
  output logic [N_CLUST*DATA_W-1:0] note_data
);
  // stage 1: request held while the array read completes
  logic              s1_v;
  op_e               s1_op;
  logic [ADDR_W-1:0] s1_addr;
  logic [DATA_W-1:0] s1_opnd;
  logic [ID_W-1:0]   s1_id;
  logic              s1_fwd;
  logic [DATA_W-1:0] s1_fwd_val;

  // stage 2: broadcast waiting for notification
  logic              s2_bc;
  logic [ADDR_W-1:0] s2_addr;
  logic [DATA_W-1:0] s2_val;

  logic [DATA_W-1:0] rd_val;
  logic [DATA_W-1:0] old_val;
  logic [DATA_W-1:0] new_val;
  logic              op_writes;
  logic              commit;

  atom_bank_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk     (clk),
    .rd_addr (req_addr),
    .rd_data (rd_val),
    .wr_en   (commit),
    .wr_addr (s1_addr),
    .wr_data (new_val)
  );

  // the array read cannot see a write that commits at the same edge
  assign old_val = s1_fwd ? s1_fwd_val : rd_val;

  atom_bank_alu #(.DATA_W(DATA_W)) u_alu (
    .op      (s1_op),
    .old_val (old_val),
    .operand (s1_opnd),
    .new_val (new_val),
    .writes  (op_writes)
  );

  assign commit = s1_v && op_writes;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v   <= 1'b0;
      s1_fwd <= 1'b0;
    end else begin
      s1_v   <= req_valid;
      s1_fwd <= req_valid && commit && (s1_addr == req_addr);
    end
    s1_op      <= op_e'(req_op);
    s1_addr    <= req_addr;
    s1_opnd    <= req_operand;
    s1_id      <= req_id;
    s1_fwd_val <= new_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_id    <= '0;
      s2_bc     <= 1'b0;
    end else begin
      rsp_valid <= s1_v;
      if (s1_v) begin
        rsp_data <= old_val;
        rsp_id   <= s1_id;
      end
      s2_bc <= s1_v && (s1_op == OP_BCAST);
    end
    s2_addr <= s1_addr;
    s2_val  <= new_val;
  end

  atom_bank_notify #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_CLUST(N_CLUST)) u_note (
    .clk        (clk),
    .rst        (rst),
    .fire       (s2_bc),
    .addr       (s2_addr),
    .data       (s2_val),
    .note_valid (note_valid),
    .note_addr  (note_addr),
    .note_data  (note_data)
  );
endmodule

// File: rtl/atom_bank_chk.sv
module atom_bank_chk #(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 32,
  parameter int ID_W    = 4,
  parameter int N_CLUST = 4
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      req_valid,
  input logic [2:0]                req_op,
  input logic [ADDR_W-1:0]         req_addr,
  input logic [ID_W-1:0]           req_id,
  input logic                      rsp_valid,
  input logic [DATA_W-1:0]         rsp_data,
  input logic [ID_W-1:0]           rsp_id,
  input logic [N_CLUST-1:0]        note_valid
);
  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> ##2 rsp_valid); // R2

  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> ##2 !rsp_valid); // R2

  AST_RSP_TAG: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_id == $past(req_id, 2))); // R2

  AST_NOTE_ALL_PORTS: assert property (@(posedge clk) disable iff (rst)
    (note_valid == '0) || (note_valid == '1)); // R8

  AST_NOTE_FROM_BCAST: assert property (@(posedge clk) disable iff (rst)
    (|note_valid) |-> ($past(req_valid, 3) && ($past(req_op, 3) == 3'd6))); // R8

  AST_LOAD_PAIR_AGREE: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(rsp_valid) && ($past(req_op, 2) == 3'd0) &&
     ($past(req_op, 3) == 3'd0) && ($past(req_addr, 2) == $past(req_addr, 3)))
    |-> (rsp_data == $past(rsp_data))); // R7
endmodule

bind atom_bank atom_bank_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .N_CLUST(N_CLUST)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_op     (req_op),
  .req_addr   (req_addr),
  .req_id     (req_id),
  .rsp_valid  (rsp_valid),
  .rsp_data   (rsp_data),
  .rsp_id     (rsp_id),
  .note_valid (note_valid)
);

// File: tb/test_atom_bank.sv
module test_atom_bank;
  localparam int ADDR_W  = 6;
  localparam int DATA_W  = 32;
  localparam int ID_W    = 4;
  localparam int N_CLUST = 4;
  localparam int DEPTH   = 1 << ADDR_W;

  logic                      clk = 1'b0;
  logic                      rst = 1'b1;
  logic                      req_valid = 1'b0;
  logic [2:0]                req_op = '0;
  logic [ADDR_W-1:0]         req_addr = '0;
  logic [DATA_W-1:0]         req_operand = '0;
  logic [ID_W-1:0]           req_id = '0;
  logic                      rsp_valid;
  logic [DATA_W-1:0]         rsp_data;
  logic [ID_W-1:0]           rsp_id;
  logic [N_CLUST-1:0]        note_valid;
  logic [N_CLUST*ADDR_W-1:0] note_addr;
  logic [N_CLUST*DATA_W-1:0] note_data;

  always #10 clk = ~clk;  // 50 MHz

  atom_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .N_CLUST(N_CLUST)) i_atom_bank (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_operand(req_operand), .req_id(req_id), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_id(rsp_id), .note_valid(note_valid), .note_addr(note_addr), .note_data(note_data)
  );

  int n_chk = 0;
  int n_fail = 0;

  logic [DATA_W-1:0] shadow [DEPTH];
  bit                known  [DEPTH];

  // history: index 0 = previous cycle's request, 1 = two back, 2 = three back
  bit                h_v     [3];
  logic [2:0]        h_op    [3];
  logic [ADDR_W-1:0] h_addr  [3];
  logic [ID_W-1:0]   h_id    [3];
  logic [DATA_W-1:0] h_old   [3];
  logic [DATA_W-1:0] h_new   [3];
  bit                h_known [3];
  bit                h_fwd   [3];

  function automatic logic [DATA_W-1:0] model_new(logic [2:0] op, logic [DATA_W-1:0] old,
                                                  logic [DATA_W-1:0] opnd);
    case (op)
      3'd1, 3'd5, 3'd6: return opnd;
      3'd2: return old + 32'd1;
      3'd3: return old - 32'd1;
      3'd4: return old + opnd;
      default: return old;
    endcase
  endfunction

  function automatic bit model_writes(logic [2:0] op);
    return (op >= 3'd1) && (op <= 3'd6);
  endfunction

  function automatic string tag_of(logic [2:0] op, bit fwd);
    if (fwd) return "R7";
    case (op)
      3'd0, 3'd1: return "R6";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4, 3'd5: return "R5";
      3'd6: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_outputs();
    chk(rsp_valid == h_v[1], "R2", "rsp_valid", 64'(rsp_valid), 64'(h_v[1]));
    if (h_v[1] && rsp_valid) begin
      chk(rsp_id == h_id[1], "R2", "rsp_id", 64'(rsp_id), 64'(h_id[1]));
      if (h_known[1])
        chk(rsp_data == h_old[1], tag_of(h_op[1], h_fwd[1]), "rsp_data",
            64'(rsp_data), 64'(h_old[1]));
    end
    if (h_v[2] && h_op[2] == 3'd6) begin
      chk(note_valid == '1, "R8", "note_valid", 64'(note_valid), 64'({N_CLUST{1'b1}}));
      for (int c = 0; c < N_CLUST; c++) begin
        chk(note_addr[c*ADDR_W +: ADDR_W] == h_addr[2], "R8", "note_addr",
            64'(note_addr[c*ADDR_W +: ADDR_W]), 64'(h_addr[2]));
        chk(note_data[c*DATA_W +: DATA_W] == h_new[2], "R8", "note_data",
            64'(note_data[c*DATA_W +: DATA_W]), 64'(h_new[2]));
      end
    end else begin
      chk(note_valid == '0, "R8", "note_valid idle", 64'(note_valid), 64'd0);
    end
  endtask

  task automatic issue(bit v, logic [2:0] op, int addr, logic [DATA_W-1:0] opnd,
                       logic [ID_W-1:0] id);
    @(negedge clk);
    check_outputs();
    for (int i = 2; i > 0; i--) begin
      h_v[i] = h_v[i-1]; h_op[i] = h_op[i-1]; h_addr[i] = h_addr[i-1];
      h_id[i] = h_id[i-1]; h_old[i] = h_old[i-1]; h_new[i] = h_new[i-1];
      h_known[i] = h_known[i-1]; h_fwd[i] = h_fwd[i-1];
    end
    req_valid   = v;
    req_op      = op;
    req_addr    = ADDR_W'(addr);
    req_operand = opnd;
    req_id      = id;
    h_v[0]     = v;
    h_op[0]    = op;
    h_addr[0]  = ADDR_W'(addr);
    h_id[0]    = id;
    h_old[0]   = shadow[addr];
    h_known[0] = known[addr];
    h_new[0]   = model_new(op, shadow[addr], opnd);
    h_fwd[0]   = v && h_v[1] && (h_addr[1] == ADDR_W'(addr)) && model_writes(h_op[1]);
    if (v && model_writes(op)) begin
      shadow[addr] = h_new[0];
      known[addr]  = 1'b1;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd5150);
    for (int i = 0; i < DEPTH; i++) begin shadow[i] = '0; known[i] = 1'b0; end
    for (int i = 0; i < 3; i++) begin
      h_v[i] = 0; h_op[i] = 0; h_addr[i] = 0; h_id[i] = 0;
      h_old[i] = 0; h_new[i] = 0; h_known[i] = 0; h_fwd[i] = 0;
    end
    repeat (4) @(negedge clk);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
    chk(note_valid == '0, "R1", "note_valid in reset", 64'(note_valid), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
    chk(note_valid == '0, "R1", "note_valid after reset", 64'(note_valid), 64'd0);

    // fill every word so later responses are predictable (R6)
    for (int a = 0; a < DEPTH; a++) issue(1, 3'd1, a, $urandom, ID_W'(a));

    // directed wrap and forwarding corners
    issue(1, 3'd1, 5, 32'hFFFF_FFFF, 4'h1);
    issue(1, 3'd2, 5, 32'h0, 4'h2);          // R3 wrap to 0, forwarded (R7)
    issue(1, 3'd0, 5, 32'h0, 4'h3);          // expect 0
    issue(1, 3'd1, 6, 32'h0, 4'h4);
    issue(0, 3'd0, 0, 32'h0, 4'h0);
    issue(1, 3'd3, 6, 32'h0, 4'h5);          // R4 wrap to all ones
    issue(0, 3'd0, 0, 32'h0, 4'h0);
    issue(1, 3'd0, 6, 32'h0, 4'h6);
    for (int k = 0; k < 6; k++) issue(1, 3'd2, 9, 32'h0, ID_W'(k)); // R7 burst
    issue(1, 3'd4, 9, 32'h7FFF_FFFF, 4'h7);  // R5 add
    issue(1, 3'd5, 9, 32'hCAFE_0001, 4'h8);  // R5 exchange
    issue(1, 3'd6, 9, 32'h1234_5678, 4'h9);  // R8 broadcast forwarded
    issue(1, 3'd0, 9, 32'h0, 4'hA);
    issue(1, 3'd7, 9, 32'hDEAD_BEEF, 4'hB);  // R9 reserved acts as load
    issue(1, 3'd0, 9, 32'h0, 4'hC);
    issue(1, 3'd6, 2, 32'hA5A5_0F0F, 4'hD);
    issue(1, 3'd6, 3, 32'h0101_0101, 4'hE);  // back-to-back broadcasts
    for (int k = 0; k < 4; k++) issue(0, 3'd0, 0, 32'h0, 4'h0);

    // constrained random phase
    for (int n = 0; n < 4000; n++) begin
      bit v;
      int a;
      v = ($urandom % 5) != 0;
      a = (($urandom % 2) == 0) ? int'($urandom % 4) : int'($urandom % DEPTH);
      issue(v, 3'($urandom % 8), a, $urandom, ID_W'($urandom));
    end
    for (int k = 0; k < 5; k++) issue(0, 3'd0, 0, 32'h0, 4'h0);
    finish_run();
  end
endmodule